// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block decides which control-store word is fetched next in a microprogrammed control unit with 128 control words. It holds a 7-bit control address register and a 7-bit return-address register. Every rising clock edge it loads the control address from one of four places: the current address plus one, the stored return address, the branch target carried by the current microinstruction, or an entry point derived from the instruction opcode.

The microinstruction supplies a 2-bit branch operation, a 2-bit condition select and a 7-bit target address. The condition select picks one of four tests: a constant true, the indirect bit, the accumulator sign, or the accumulator-zero flag. Jumps and calls happen only when that test is true; otherwise execution falls through to the next word. A taken call stores the fall-through address as the single return address. Returns and opcode dispatches ignore the test. The control store and the datapath registers are outside this block; the address register drives the control store directly.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset loads the control address with 64 (start of the fetch routine) and clears the return-address register.
- R2: The condition select works as follows: 00 gives a constant true, 01 the indirect bit `indBit`, 10 the sign bit `signBit`, and 11 the zero flag `zeroBit`.
- R3: Branch operation 00 (jump) loads the target `branchAddr` when the selected condition is true, and the current address plus one when it is false.
- R4: Branch operation 01 (call) loads the target into the control address and the current address plus one into the return-address register when the condition is true. When the condition is false it loads the current address plus one and keeps the return address.
- R5: Branch operation 10 (return) loads the return-address register into the control address, whatever the condition.
- R6: Branch operation 11 (dispatch) loads the control address with bit 6 = 0, bits 5..2 = `opCode`, and bits 1..0 = 00, whatever the condition.
- R7: The return-address register changes only on a taken call. Jumps, returns, dispatches and untaken calls leave it unchanged.
- R8: The address-plus-one path wraps from 127 to 0, both when it goes to the control address and when it goes to the return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| condSel | input | 2 | Condition select field of the current microinstruction |
| branchOp | input | 2 | Branch operation field of the current microinstruction |
| branchAddr | input | 7 | Branch or call target field of the current microinstruction |
| indBit | input | 1 | Indirect-address status bit |
| signBit | input | 1 | Accumulator sign status bit |
| zeroBit | input | 1 | High when the accumulator is zero |
| opCode | input | 4 | Instruction opcode used by the dispatch operation |
| carOut | output | 7 | Current control address |
| sbrOut | output | 7 | Current return address |

## Verification
A taken call updates both registers on the same edge: the control address takes the target, and the return-address register takes the old address plus one. The bench triggers this from address 127, so the stored return address must wrap to 0 while the target is loaded. A return follows at once and must read the value written on the edge before it. Each register is checked against a bench-side model after every edge. This catches swapped sources, a stale return address, or a missing wrap.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    SRC_INC = 2'b00,
    SRC_SBR = 2'b01,
    SRC_AD  = 2'b10,
    SRC_MAP = 2'b11
  } srcSel_e;

  typedef enum logic [1:0] {
    OP_JMP  = 2'b00,
    OP_CALL = 2'b01,
    OP_RET  = 2'b10,
    OP_MAP  = 2'b11
  } branchOp_e;

  typedef struct packed {
    srcSel_e src;
    logic    loadSbr;
  } seqStrobe_t;

endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int COND_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] condSel,
  input  logic [1:0]        branchOp,
  input  logic              indBit,
  input  logic              signBit,
  input  logic              zeroBit,
  output seqStrobe_t        strb
);

  localparam int NUM_COND = 1 << COND_W;

  logic [NUM_COND-1:0] condVec;
  logic                condTrue;

  assign condVec  = {zeroBit, signBit, indBit, 1'b1};
  assign condTrue = condVec[condSel];

  always_comb begin
    strb.src     = SRC_INC;
    strb.loadSbr = 1'b0;
    unique case (branchOp_e'(branchOp))
      OP_JMP:  strb.src = condTrue ? SRC_AD : SRC_INC;
      OP_CALL: begin
        strb.src     = condTrue ? SRC_AD : SRC_INC;
        strb.loadSbr = condTrue;
      end
      OP_RET:  strb.src = SRC_SBR;
      OP_MAP:  strb.src = SRC_MAP;
      default: strb.src = SRC_INC;
    endcase
  end

  p_ret_src_r5: assert property (@(posedge clk) disable iff (rst)
    (branchOp == OP_RET) |-> (strb.src == SRC_SBR && !strb.loadSbr));

  p_map_src_r6: assert property (@(posedge clk) disable iff (rst)
    (branchOp == OP_MAP) |-> (strb.src == SRC_MAP && !strb.loadSbr));

  p_uncond_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (branchOp == OP_JMP && condSel == 2'b00) |-> (strb.src == SRC_AD));

  p_sbr_only_call_r7: assert property (@(posedge clk) disable iff (rst)
    strb.loadSbr |-> (branchOp == OP_CALL && strb.src == SRC_AD));

endmodule

// File: rtl/useq_dpath.sv
module useq_dpath
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int MAP_LSB    = 2,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] branchAddr,
  input  logic [OPC_W-1:0]  opCode,
  output logic [ADDR_W-1:0] carQ,
  output logic [ADDR_W-1:0] sbrQ
);

  localparam logic [ADDR_W-1:0] RST_CAR = ADDR_W'(RESET_ADDR);

  logic [ADDR_W-1:0] carInc;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] carNext;

  assign carInc = carQ + 1'b1;

  always_comb begin
    mapAddr = '0;
    mapAddr[MAP_LSB +: OPC_W] = opCode;
  end

  always_comb begin
    unique case (strb.src)
      SRC_INC: carNext = carInc;
      SRC_SBR: carNext = sbrQ;
      SRC_AD:  carNext = branchAddr;
      SRC_MAP: carNext = mapAddr;
      default: carNext = carInc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carQ <= RST_CAR;
      sbrQ <= '0;
    end else begin
      carQ <= carNext;
      if (strb.loadSbr) sbrQ <= carInc;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (carQ == RST_CAR && sbrQ == '0));

  p_sbr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.loadSbr |=> $stable(sbrQ));

  p_call_link_r4: assert property (@(posedge clk) disable iff (rst)
    strb.loadSbr |=> (sbrQ == ADDR_W'($past(carQ) + 1'b1)));

  p_ret_load_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.src == SRC_SBR) |=> (carQ == $past(sbrQ)));

  p_map_form_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.src == SRC_MAP) |=> (carQ[MAP_LSB-1:0] == '0 && carQ[ADDR_W-1] == 1'b0));

  p_inc_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (strb.src == SRC_INC && carQ == {ADDR_W{1'b1}}) |=> (carQ == '0));

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int MAP_LSB    = 2,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        condSel,
  input  logic [1:0]        branchOp,
  input  logic [ADDR_W-1:0] branchAddr,
  input  logic              indBit,
  input  logic              signBit,
  input  logic              zeroBit,
  input  logic [OPC_W-1:0]  opCode,
  output logic [ADDR_W-1:0] carOut,
  output logic [ADDR_W-1:0] sbrOut
);

  seqStrobe_t strb;

  useq_ctrl #(.COND_W(2)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .condSel  (condSel),
    .branchOp (branchOp),
    .indBit   (indBit),
    .signBit  (signBit),
    .zeroBit  (zeroBit),
    .strb     (strb)
  );

  useq_dpath #(
    .ADDR_W     (ADDR_W),
    .OPC_W      (OPC_W),
    .MAP_LSB    (MAP_LSB),
    .RESET_ADDR (RESET_ADDR)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .branchAddr (branchAddr),
    .opCode     (opCode),
    .carQ       (carOut),
    .sbrQ       (sbrOut)
  );

endmodule

// File: tb/sim_useq_top.sv
`timescale 1ns/1ps
module sim_useq_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] condSel = 2'b00;
  logic [1:0] branchOp = 2'b00;
  logic [6:0] branchAddr = '0;
  logic       indBit = 1'b0;
  logic       signBit = 1'b0;
  logic       zeroBit = 1'b0;
  logic [3:0] opCode = '0;
  logic [6:0] carOut;
  logic [6:0] sbrOut;

  int total = 0;
  int bad = 0;
  logic [6:0] expCar = 7'd64;
  logic [6:0] expSbr = 7'd0;

  always #10 clk = ~clk;

  useq_top u0 (
    .clk(clk), .rst(rst), .condSel(condSel), .branchOp(branchOp),
    .branchAddr(branchAddr), .indBit(indBit), .signBit(signBit),
    .zeroBit(zeroBit), .opCode(opCode), .carOut(carOut), .sbrOut(sbrOut)
  );

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one microinstruction: drive at negedge, clock, compare at next negedge
  task automatic step(input string tag, input logic [1:0] cd, input logic [1:0] br,
                      input logic [6:0] ad, input logic [2:0] st, input logic [3:0] opc);
    logic cond;
    logic [6:0] inc;
    condSel = cd; branchOp = br; branchAddr = ad;
    {zeroBit, signBit, indBit} = st; opCode = opc;
    case (cd)
      2'b00: cond = 1'b1;
      2'b01: cond = st[0];
      2'b10: cond = st[1];
      default: cond = st[2];
    endcase
    inc = expCar + 7'd1;
    case (br)
      2'b00: expCar = cond ? ad : inc;
      2'b01: begin
        if (cond) expSbr = inc;
        expCar = cond ? ad : inc;
      end
      2'b10: expCar = expSbr;
      default: expCar = {1'b0, opc, 2'b00};
    endcase
    @(posedge clk);
    @(negedge clk);
    check({tag, " car"}, carOut, expCar);
    check({tag, " sbr"}, sbrOut, expSbr);
  endtask

  task automatic t_reset_r1();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    expCar = 7'd64; expSbr = 7'd0;
    check("R1 reset car", carOut, 7'd64);
    check("R1 reset sbr", sbrOut, 7'd0);
  endtask

  task automatic t_cond_r2();
    step("R2 cd01 ind=1 taken", 2'b01, 2'b00, 7'd20, 3'b001, 4'd0);
    step("R2 cd01 ind=0 fall",  2'b01, 2'b00, 7'd90, 3'b110, 4'd0);
    step("R2 cd10 sign=1 taken", 2'b10, 2'b00, 7'd33, 3'b010, 4'd0);
    step("R2 cd10 sign=0 fall",  2'b10, 2'b00, 7'd99, 3'b101, 4'd0);
    step("R2 cd11 zero=1 taken", 2'b11, 2'b00, 7'd50, 3'b100, 4'd0);
    step("R2 cd11 zero=0 fall",  2'b11, 2'b00, 7'd5,  3'b011, 4'd0);
  endtask

  task automatic t_jump_r3();
    step("R3 jmp uncond", 2'b00, 2'b00, 7'd100, 3'b000, 4'd0);
    step("R3 jmp untaken", 2'b01, 2'b00, 7'd7, 3'b000, 4'd0);
  endtask

  task automatic t_call_r4_r7();
    step("R4 call taken", 2'b00, 2'b01, 7'd70, 3'b000, 4'd0);
    step("R4 R7 call untaken keeps sbr", 2'b10, 2'b01, 7'd12, 3'b000, 4'd0);
    step("R7 jmp keeps sbr", 2'b00, 2'b00, 7'd3, 3'b000, 4'd0);
    step("R7 map keeps sbr", 2'b00, 2'b11, 7'd0, 3'b111, 4'd9);
  endtask

  task automatic t_ret_r5();
    step("R5 ret cond false", 2'b11, 2'b10, 7'd44, 3'b000, 4'd0);
    step("R5 ret cond true", 2'b00, 2'b10, 7'd44, 3'b111, 4'd0);
  endtask

  task automatic t_map_r6();
    step("R6 map op0010", 2'b01, 2'b11, 7'd127, 3'b000, 4'b0010);
    step("R6 map op1011", 2'b00, 2'b11, 7'd1, 3'b111, 4'b1011);
    step("R6 map op1111", 2'b10, 2'b11, 7'd0, 3'b010, 4'b1111);
  endtask

  task automatic t_wrap_r8();
    step("R8 jmp to 127", 2'b00, 2'b00, 7'd127, 3'b000, 4'd0);
    step("R8 inc wraps", 2'b01, 2'b00, 7'd55, 3'b000, 4'd0);
    step("R8 jmp to 127 again", 2'b00, 2'b00, 7'd127, 3'b000, 4'd0);
    step("R8 R4 call from 127", 2'b00, 2'b01, 7'd80, 3'b000, 4'd0);
    step("R8 R5 ret to wrapped", 2'b00, 2'b10, 7'd0, 3'b000, 4'd0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset_r1();
        t_cond_r2();
        t_jump_r3();
        t_call_r4_r7();
        t_ret_r5();
        t_map_r6();
        t_wrap_r8();
        step("R1 setup before reset", 2'b00, 2'b01, 7'd9, 3'b000, 4'd0);
        t_reset_r1();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule